// File: doc/BRIEF.md
# UART CPU Register Interface

This block is the processor-facing side of a serial port. A narrow synchronous bus carries a one-bit address, write and read strobes, and eight bits of data in each direction. Behind that bus sit a transmitter and a receiver, both built in. The transmitter sends a frame of one start bit, eight data bits and one stop bit, least significant bit first. The receiver brings the line in through a two-flop synchronizer, checks the start bit at its midpoint and samples each later bit one bit period apart.

Software drives the port through two locations. Location 0 is the data location. A write there hands a byte to the transmitter. A read there collects the received byte. Location 1 is the status location and is read-only. Reads change state. Collecting the data re-arms the receiver. A status read that sees a framing error clears the error and re-arms the receiver in the same cycle. After a byte has been received, or a framing error has been seen, the receiver ignores the line until software re-arms it.

Top module: `uart_regif`

## Requirements
- R1: After reset the transmit line is high. A status read returns 0x04: bit 2 (transmitter ready) is set and every other bit is clear.
- R2: A write to location 0 takes bits 7:0 of the write data as the byte to send. The transmitter leaves idle at that clock edge and status bit 2 reads 0. The line then carries a low start bit, the eight data bits LSB first and a high stop bit, each CLKS_PER_BIT clocks long. Status bit 2 returns to 1 once the stop bit ends.
- R3: A write to location 1 has no effect. The transmit line stays high and status still reads 0x04.
- R4: A write to location 0 while a frame is being sent is accepted. It replaces the pending byte and restarts the frame from its start bit, so the line carries the new byte.
- R5: A frame with a high stop bit sets status bit 0 (receive ready) and leaves bit 1 clear.
- R6: A frame with a low stop bit sets status bit 1 (receive error) and leaves bit 0 clear. A status read that returns bit 1 set also re-arms the receiver, so the next status read shows bits 1:0 both clear. Bits 0 and 1 are never set together; a full receiver is reported ahead of an error.
- R7: A read of location 0 returns the received byte and re-arms the receiver. After that, status bit 0 reads 0 and a new frame can be received.
- R8: A status read while the receiver holds a good byte does not change it. Bit 0 stays set on later status reads.
- R9: Read data is registered: the value appears one clock after the read strobe. It is zero in every cycle that follows a clock with no read strobe. Status bits 7:3 always read zero.
- R10: While the receiver holds a byte or an error, activity on the receive line is ignored. The byte kept is the first one received.
- R11: A synchronous reset asserted in the middle of a frame returns both the transmitter and the receiver to idle. The line goes high and status reads 0x04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | Location select: 0 data, 1 status |
| bus_wr | input | 1 | Write strobe, one clock per access |
| bus_rd | input | 1 | Read strobe, one clock per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, zero when no read was strobed |
| ser_tx | output | 1 | Serial transmit line, high when idle |
| ser_rx | input | 1 | Serial receive line, high when idle |

## Verification
Transmit and receive bytes are drawn at random from a fixed seed, so many different bit patterns cross the frame. A bit-order or bit-count fault therefore shows up as a wrong byte rather than passing by chance. Some received frames are given a low stop bit at random, which exercises the full path and the error path back to back and shows whether each read clears only what it should. Directed cases cover the rest:
- a write to the status location;
- a second write in the middle of a frame;
- repeated status reads while a byte is held;
- a second frame sent while a byte is held;
- a reset in the middle of a frame.

These separate side effects that a normal receive-and-read sequence would hide.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned BIT_W  = $clog2(BYTE_W);

    localparam logic LOC_DATA = 1'b0;
    localparam logic LOC_STAT = 1'b1;

    localparam int unsigned ST_RX_READY = 0;
    localparam int unsigned ST_RX_ERROR = 1;
    localparam int unsigned ST_TX_READY = 2;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_FULL,
        RX_ERR
    } rx_state_e;

    typedef struct packed {
        logic              load;
        logic [BYTE_W-1:0] data;
    } tx_cmd_t;

    typedef struct packed {
        logic              full;
        logic              err;
        logic [BYTE_W-1:0] data;
    } rx_view_t;

    // Full is checked before error so the two flags never appear together.
    function automatic logic [BYTE_W-1:0] pack_status(input logic rx_full,
                                                      input logic rx_err,
                                                      input logic tx_idle);
        logic [BYTE_W-1:0] s;
        s = '0;
        if (rx_full) begin
            s[ST_RX_READY] = 1'b1;
        end else if (rx_err) begin
            s[ST_RX_ERROR] = 1'b1;
        end
        s[ST_TX_READY] = tx_idle;
        return s;
    endfunction

endpackage

// File: rtl/uart_regif_tx.sv
module uart_regif_tx
    import uart_regif_pkg::*;
#(
    parameter int unsigned CLKS_PER_BIT = 16
) (
    input  logic    clk,
    input  logic    rst,
    input  tx_cmd_t cmd,
    output logic    txd,
    output logic    idle
);

    localparam int unsigned CNT_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLKS_PER_BIT - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);

    tx_state_e         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] shreg_q;
    logic [BIT_W-1:0]  bit_q;
    logic              tick;

    assign tick = (cnt_q == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TX_IDLE;
            cnt_q   <= '0;
            shreg_q <= '0;
            bit_q   <= '0;
        end else if (cmd.load) begin
            // A load always restarts the frame, even mid-transmission.
            state_q <= TX_START;
            cnt_q   <= '0;
            shreg_q <= cmd.data;
            bit_q   <= '0;
        end else begin
            case (state_q)
                TX_IDLE: begin
                    cnt_q <= '0;
                end
                TX_START: begin
                    if (tick) begin
                        cnt_q   <= '0;
                        state_q <= TX_DATA;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                TX_DATA: begin
                    if (tick) begin
                        cnt_q   <= '0;
                        shreg_q <= {1'b0, shreg_q[BYTE_W-1:1]};
                        if (bit_q == BIT_LAST) begin
                            state_q <= TX_STOP;
                            bit_q   <= '0;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                TX_STOP: begin
                    if (tick) begin
                        cnt_q   <= '0;
                        state_q <= TX_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= TX_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    always_comb begin
        case (state_q)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = shreg_q[0];
            default:  txd = 1'b1;
        endcase
    end

    assign idle = (state_q == TX_IDLE);

    AST_TX_LOAD_RESTART: assert property (@(posedge clk) disable iff (rst)
        cmd.load |=> (state_q == TX_START && shreg_q == $past(cmd.data))); // R4

    AST_TX_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
        (idle && !cmd.load) |=> idle); // R3

    AST_TX_START_LOW: assert property (@(posedge clk) disable iff (rst)
        cmd.load |=> !txd); // R2

endmodule

// File: rtl/uart_regif_rx.sv
module uart_regif_rx
    import uart_regif_pkg::*;
#(
    parameter int unsigned CLKS_PER_BIT = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     rxd,
    input  logic     restart,
    output rx_view_t view
);

    localparam int unsigned CNT_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(CLKS_PER_BIT - 1);
    localparam int unsigned      HALF      = (CLKS_PER_BIT >= 2) ? CLKS_PER_BIT / 2 : 1;
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF - 1);
    localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(BYTE_W - 1);

    logic              meta_q;
    logic              sync_q;
    rx_state_e         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BIT_W-1:0]  bit_q;
    logic [BYTE_W-1:0] shreg_q;
    logic [BYTE_W-1:0] data_q;
    logic              tick;

    assign tick = (cnt_q == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
        end else begin
            meta_q <= rxd;
            sync_q <= meta_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            shreg_q <= '0;
            data_q  <= '0;
        end else if (restart) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
        end else begin
            case (state_q)
                RX_IDLE: begin
                    cnt_q <= '0;
                    bit_q <= '0;
                    if (!sync_q) begin
                        state_q <= RX_START;
                    end
                end
                RX_START: begin
                    if (cnt_q == HALF_LAST) begin
                        cnt_q   <= '0;
                        state_q <= sync_q ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        cnt_q   <= '0;
                        shreg_q <= {sync_q, shreg_q[BYTE_W-1:1]};
                        if (bit_q == BIT_LAST) begin
                            state_q <= RX_STOP;
                            bit_q   <= '0;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        cnt_q <= '0;
                        if (sync_q) begin
                            state_q <= RX_FULL;
                            data_q  <= shreg_q;
                        end else begin
                            state_q <= RX_ERR;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_FULL, RX_ERR: begin
                    cnt_q <= '0;
                end
                default: begin
                    state_q <= RX_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    assign view.full = (state_q == RX_FULL);
    assign view.err  = (state_q == RX_ERR);
    assign view.data = data_q;

    AST_RX_RESTART_IDLE: assert property (@(posedge clk) disable iff (rst)
        restart |=> (state_q == RX_IDLE)); // R7

    AST_RX_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state_q == RX_FULL && !restart) |=> (state_q == RX_FULL && $stable(data_q))); // R10

    AST_RX_ERR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state_q == RX_ERR && !restart) |=> (state_q == RX_ERR)); // R10

endmodule

// File: rtl/uart_regif_bus.sv
module uart_regif_bus
    import uart_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  rx_view_t          rx,
    input  logic              tx_idle,
    output tx_cmd_t           tx_cmd,
    output logic              rx_restart
);

    logic [BYTE_W-1:0] status;
    logic [BYTE_W-1:0] rdata_d;
    logic [BYTE_W-1:0] rdata_q;

    assign status = pack_status(rx.full, rx.err, tx_idle);

    always_comb begin
        tx_cmd.load = wr && (addr == LOC_DATA);
        tx_cmd.data = wdata;
    end

    always_comb begin
        rx_restart = 1'b0;
        if (rd) begin
            if (addr == LOC_DATA) begin
                rx_restart = 1'b1;
            end else if (rx.err && !rx.full) begin
                rx_restart = 1'b1;
            end
        end
    end

    always_comb begin
        rdata_d = '0;
        if (rd) begin
            rdata_d = (addr == LOC_DATA) ? rx.data : status;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;

    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rd |=> (rdata == '0)); // R9

    AST_STAT_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == LOC_STAT) |=> (rdata[BYTE_W-1:ST_TX_READY+1] == '0)); // R9

    AST_STAT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == LOC_STAT) |=> !(rdata[ST_RX_READY] && rdata[ST_RX_ERROR])); // R6

    AST_ERR_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == LOC_STAT && rx.err) |=> !rx.err); // R6

    AST_STAT_WRITE_INERT: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == LOC_STAT && tx_idle) |=> tx_idle); // R3

    AST_FULL_READ_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == LOC_STAT && rx.full) |=> rx.full); // R8

endmodule

// File: rtl/uart_regif.sv
module uart_regif
    import uart_regif_pkg::*;
#(
    parameter int unsigned CLKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       ser_tx,
    input  logic       ser_rx
);

    tx_cmd_t  tx_cmd;
    rx_view_t rx_view;
    logic     tx_idle;
    logic     rx_restart;

    uart_regif_bus u_bus (
        .clk        (clk),
        .rst        (rst),
        .addr       (bus_addr),
        .wr         (bus_wr),
        .rd         (bus_rd),
        .wdata      (bus_wdata),
        .rdata      (bus_rdata),
        .rx         (rx_view),
        .tx_idle    (tx_idle),
        .tx_cmd     (tx_cmd),
        .rx_restart (rx_restart)
    );

    uart_regif_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
        .clk  (clk),
        .rst  (rst),
        .cmd  (tx_cmd),
        .txd  (ser_tx),
        .idle (tx_idle)
    );

    uart_regif_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .rxd     (ser_rx),
        .restart (rx_restart),
        .view    (rx_view)
    );

    AST_TOP_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> (ser_tx && bus_rdata == '0)); // R11

endmodule

// File: tb/uart_regif_bench.sv
module uart_regif_bench;

    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_addr = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       ser_tx;
    logic       ser_rx = 1'b1;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    uart_regif #(.CLKS_PER_BIT(N)) u_uart_regif (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ser_tx    (ser_tx),
        .ser_rx    (ser_rx)
    );

    function automatic logic [7:0] exp_status(input logic full, input logic err,
                                              input logic txr);
        logic [7:0] s;
        s = 8'h00;
        if (full) s[0] = 1'b1;
        else if (err) s[1] = 1'b1;
        s[2] = txr;
        return s;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
        d = bus_rdata;
    endtask

    // Called right after bus_write returns: half a clock into the start bit.
    task automatic tx_capture(input string req, input logic [7:0] exp);
        logic [7:0] got;
        logic       st;
        logic       sp;
        repeat (N / 2) @(negedge clk);
        st = ser_tx;
        for (int i = 0; i < 8; i++) begin
            repeat (N) @(negedge clk);
            got[i] = ser_tx;
        end
        repeat (N) @(negedge clk);
        sp = ser_tx;
        chk({req, " start bit"}, {7'd0, st}, 8'h00);
        chk({req, " data"}, got, exp);
        chk({req, " stop bit"}, {7'd0, sp}, 8'h01);
    endtask

    task automatic rx_send(input logic [7:0] b, input logic stop);
        @(negedge clk);
        ser_rx = 1'b0;
        repeat (N) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            ser_rx = b[i];
            repeat (N) @(negedge clk);
        end
        ser_rx = stop;
        repeat (N) @(negedge clk);
        ser_rx = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [7:0] a;
        logic [7:0] b;
        void'($urandom(32'h5eed_0042));
        do_reset();

        // R1 reset state
        chk("R1 tx line", {7'd0, ser_tx}, 8'h01);
        bus_read(1'b1, d);
        chk("R1 status", d, exp_status(1'b0, 1'b0, 1'b1));

        // R9 quiet read data after a read
        @(negedge clk);
        chk("R9 rdata zero without strobe", bus_rdata, 8'h00);

        // R3 write to status location ignored
        bus_write(1'b1, 8'h55);
        chk("R3 tx line after status write", {7'd0, ser_tx}, 8'h01);
        repeat (3) @(negedge clk);
        chk("R3 tx line later", {7'd0, ser_tx}, 8'h01);
        bus_read(1'b1, d);
        chk("R3 status", d, exp_status(1'b0, 1'b0, 1'b1));

        // R2 directed edge patterns
        bus_write(1'b0, 8'h00);
        tx_capture("R2 all-zero", 8'h00);
        repeat (N) @(negedge clk);
        bus_write(1'b0, 8'hFF);
        tx_capture("R2 all-one", 8'hFF);
        repeat (N) @(negedge clk);
        bus_read(1'b1, d);
        chk("R2 ready after frame", d, exp_status(1'b0, 1'b0, 1'b1));

        // R4 overwrite while busy, plus R2 busy status
        bus_write(1'b0, 8'h3C);
        bus_read(1'b1, d);
        chk("R2 busy status", d, exp_status(1'b0, 1'b0, 1'b0));
        repeat (3 * N) @(negedge clk);
        bus_write(1'b0, 8'hA6);
        tx_capture("R4 overwritten byte", 8'hA6);
        repeat (N) @(negedge clk);
        bus_read(1'b1, d);
        chk("R4 ready after restart", d, exp_status(1'b0, 1'b0, 1'b1));

        // R5 R8 R7 directed receive
        rx_send(8'h81, 1'b1);
        bus_read(1'b1, d);
        chk("R5 status full", d, exp_status(1'b1, 1'b0, 1'b1));
        bus_read(1'b1, d);
        chk("R8 status still full", d, exp_status(1'b1, 1'b0, 1'b1));
        // R10 second frame while full is ignored
        rx_send(8'h7E, 1'b1);
        bus_read(1'b0, d);
        chk("R10 first byte kept", d, 8'h81);
        bus_read(1'b1, d);
        chk("R7 rearmed status", d, exp_status(1'b0, 1'b0, 1'b1));

        // R6 error path
        rx_send(8'h42, 1'b0);
        bus_read(1'b1, d);
        chk("R6 status error", d, exp_status(1'b0, 1'b1, 1'b1));
        bus_read(1'b1, d);
        chk("R6 error cleared", d, exp_status(1'b0, 1'b0, 1'b1));
        rx_send(8'hC3, 1'b1);
        bus_read(1'b0, d);
        chk("R7 receive after error", d, 8'hC3);

        // Random mix
        for (int it = 0; it < 8; it++) begin
            a = 8'($urandom);
            b = 8'($urandom);
            bus_write(1'b0, a);
            tx_capture("R2 random", a);
            repeat (N) @(negedge clk);
            if (($urandom % 4) == 0) begin
                rx_send(b, 1'b0);
                bus_read(1'b1, d);
                chk("R6 random error", d, exp_status(1'b0, 1'b1, 1'b1));
                bus_read(1'b1, d);
                chk("R6 random clear", d, exp_status(1'b0, 1'b0, 1'b1));
            end else begin
                rx_send(b, 1'b1);
                bus_read(1'b1, d);
                chk("R5 random full", d, exp_status(1'b1, 1'b0, 1'b1));
                bus_read(1'b0, d);
                chk("R7 random byte", d, b);
                bus_read(1'b1, d);
                chk("R7 random rearm", d, exp_status(1'b0, 1'b0, 1'b1));
            end
        end

        // R11 reset during a frame in both directions
        bus_write(1'b0, 8'h00);
        fork
            rx_send(8'h5A, 1'b1);
            begin
                repeat (2 * N) @(negedge clk);
                rst = 1'b1;
                @(negedge clk);
                rst = 1'b0;
                chk("R11 tx line after reset", {7'd0, ser_tx}, 8'h01);
            end
        join
        bus_read(1'b1, d);
        chk("R11 status after reset", d, exp_status(1'b0, 1'b0, 1'b1));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule